// File: doc/BRIEF.md
# Control-Coded Bit-Slice ALU

This block is an N-bit arithmetic and logic unit assembled from identical one-bit slices. Each slice forms a propagate term (A XOR B) and a generate term (A AND B) from its two operand bits. It then builds its result bit and its outgoing carry from those two terms and the incoming carry. The carry ripples from the least significant slice upward. There is no lookahead structure.

A three-bit mode word selects addition, bitwise AND, bitwise OR or bitwise XOR, and every slice shares it. The external carry input, the carry output and the result bus are all active-low. The outputs are registered, so a result appears one clock after its operands and mode. The block fits a datapath where the mode comes straight from a small control field.

Top module: `bsalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `res_n` all ones and `cout_n` high. This holds even if operands and an add mode are presented in that same cycle.
- R2: `res_n` and `cout_n` change only at a rising clock edge. They reflect the `mode`, `opa`, `opb` and `cin_n` values sampled at that edge, so the latency is one cycle.
- R3: With `mode` = 3'b100 (bit 2 is the first control bit, bit 0 the third), ~`res_n` equals the low W bits of `opa` + `opb` + c. Here c is 1 when `cin_n` is low.
- R4: In the R3 mode, `cout_n` is low exactly when the sum in R3 carries out of bit W-1.
- R5: With `mode` = 3'b110, ~`res_n` equals `opa` AND `opb`.
- R6: With `mode` = 3'b001, ~`res_n` equals `opa` OR `opb`.
- R7: With `mode` = 3'b101, ~`res_n` equals `opa` XOR `opb`.
- R8: In the R5, R6 and R7 modes, `cout_n` is high and `cin_n` has no effect on either output.
- R9: For any other `mode` value, `res_n` is all ones and `cout_n` is high.
- R10: The carry ripples slice to slice. An all-ones operand plus zero with `cin_n` low gives a result of zero and a carry out, so the carry has passed through every slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Operation select; bit 2 is the first control bit |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| cin_n | input | 1 | Carry into bit 0, active low |
| res_n | output | W | Registered result, active low |
| cout_n | output | 1 | Registered carry out of bit W-1, active low |

## Verification
Two things can fall in the same cycle: a synchronous reset and a fully valid add whose carry ripples across every slice. The bench drives all-ones plus zero with the carry input asserted while `rst` is high. It expects the idle output (all ones, carry inactive) in the next cycle. It then repeats the same operands with reset low and expects a zero result with `cout_n` low. This shows that reset overrides a live full-width ripple. It also shows that the ripple itself is intact once reset is released.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  // Decoded operation carried to every slice
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4
  } alu_op_e;

  // Mode word encodings: bit 2 = first control bit, bit 0 = third
  localparam logic [2:0] MODE_ADD = 3'b100;
  localparam logic [2:0] MODE_AND = 3'b110;
  localparam logic [2:0] MODE_OR  = 3'b001;
  localparam logic [2:0] MODE_XOR = 3'b101;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
  import bsalu_pkg::*;
(
  input  logic [2:0] mode,
  output alu_op_e    op,
  output logic       use_carry
);

  always_comb begin
    unique case (mode)
      MODE_ADD: op = OP_ADD;
      MODE_AND: op = OP_AND;
      MODE_OR:  op = OP_OR;
      MODE_XOR: op = OP_XOR;
      default:  op = OP_NONE;
    endcase
  end

  assign use_carry = (op == OP_ADD);

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  alu_op_e op,
  input  logic    a,
  input  logic    b,
  input  logic    cy_in,
  output logic    r,
  output logic    cy_out
);

  logic prop;
  logic gen;

  assign prop = a ^ b;
  assign gen  = a & b;

  // carry always formed from the two terms; the top decides whether it counts
  assign cy_out = gen | (prop & cy_in);

  always_comb begin
    unique case (op)
      OP_ADD:  r = prop ^ cy_in;
      OP_AND:  r = gen;
      OP_OR:   r = prop | gen;
      OP_XOR:  r = prop;
      default: r = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin_n,
  output logic [W-1:0] res_n,
  output logic         cout_n
);

  localparam int CHAIN = W + 1;

  alu_op_e          op;
  logic             use_carry;
  logic [CHAIN-1:0] chain;
  logic [W-1:0]     res_t;
  logic [W-1:0]     res_n_q;
  logic             cout_n_q;

  bsalu_decode u_dec (
    .mode      (mode),
    .op        (op),
    .use_carry (use_carry)
  );

  assign chain[0] = ~cin_n;

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      bsalu_slice u_slice (
        .op     (op),
        .a      (opa[i]),
        .b      (opb[i]),
        .cy_in  (chain[i]),
        .r      (res_t[i]),
        .cy_out (chain[i+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_n_q  <= '1;
      cout_n_q <= 1'b1;
    end else begin
      res_n_q  <= ~res_t;
      cout_n_q <= ~(use_carry & chain[W]);
    end
  end

  assign res_n  = res_n_q;
  assign cout_n = cout_n_q;

endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   mode,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         cin_n,
  input logic [W-1:0] res_n,
  input logic         cout_n
);

  localparam int XW = W + 1;

  logic valid_op;
  assign valid_op = (mode == 3'b100) || (mode == 3'b110) ||
                    (mode == 3'b001) || (mode == 3'b101);

  // R1: reset leaves the outputs idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (res_n == {W{1'b1}} && cout_n));

  // R3 R4: add result and carry out
  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'b100) |->
      ({~cout_n, ~res_n} == ({1'b0, $past(opa)} + {1'b0, $past(opb)} +
                             XW'(!$past(cin_n)))));

  // R5
  p_and_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'b110) |-> (~res_n == ($past(opa) & $past(opb))));

  // R6
  p_or_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'b001) |-> (~res_n == ($past(opa) | $past(opb))));

  // R7
  p_xor_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'b101) |-> (~res_n == ($past(opa) ^ $past(opb))));

  // R8 R9: carry out inactive outside add
  p_cout_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 3'b100) |-> cout_n);

  // R9: undefined codes give an all-zero true result
  p_undef_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_op)) |-> (res_n == {W{1'b1}}));

  // R2: outputs only move when something was sampled that moves them
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) && $stable(mode) && $stable(opa) && $stable(opb) &&
     $stable(cin_n)) |=> ($stable(res_n) && $stable(cout_n)));

endmodule

bind bsalu_top bsalu_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mode   (mode),
  .opa    (opa),
  .opb    (opb),
  .cin_n  (cin_n),
  .res_n  (res_n),
  .cout_n (cout_n)
);

// File: tb/sim_bsalu_top.sv
module sim_bsalu_top;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   mode;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         cin_n;
  logic [W-1:0] res_n;
  logic         cout_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bsalu_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .opa(opa), .opb(opb),
    .cin_n(cin_n), .res_n(res_n), .cout_n(cout_n)
  );

  // behavioural model: returns {cout_n, res_n}
  function automatic logic [W:0] model(input logic [2:0] m, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic cn);
    logic [W:0] s;
    case (m)
      3'b100: begin
        s = {1'b0, a} + {1'b0, b} + (W+1)'(!cn);
        return ~s;
      end
      3'b110:  return {1'b1, ~(a & b)};
      3'b001:  return {1'b1, ~(a | b)};
      3'b101:  return {1'b1, ~(a ^ b)};
      default: return {1'b1, {W{1'b1}}};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b100:  return "R3/R4";
      3'b110:  return "R5/R8";
      3'b001:  return "R6/R8";
      3'b101:  return "R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] exp);
    tests++;
    if ({cout_n, res_n} !== exp) begin
      fails++;
      $display("FAIL %s: got cout_n=%b res_n=%h, expected cout_n=%b res_n=%h",
               req, cout_n, res_n, exp[W], exp[W-1:0]);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run(input logic [2:0] m, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic cn, input string req);
    @(negedge clk);
    mode = m; opa = a; opb = b; cin_n = cn;
    @(negedge clk);
    check(req, model(m, a, b, cn));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; mode = 3'b100; opa = '1; opb = '0; cin_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset overrides a live full-width add ripple
    check("R1", {1'b1, {W{1'b1}}});
    rst = 1'b0;
    @(negedge clk);
    // R10: all-ones + 0 + carry ripples through every slice
    check("R10", {1'b0, {W{1'b1}}});

    // R2: result follows one cycle later and holds
    run(3'b100, 8'd3, 8'd4, 1'b1, "R2");
    @(negedge clk);
    check("R2", model(3'b100, 8'd3, 8'd4, 1'b1));

    // directed corners
    run(3'b100, '1, '1, 1'b0, "R4");
    run(3'b100, '0, '0, 1'b1, "R3");
    run(3'b100, 8'h80, 8'h80, 1'b1, "R4");
    run(3'b110, '1, '1, 1'b0, "R8");
    run(3'b001, '0, '0, 1'b0, "R8");
    run(3'b101, 8'hA5, 8'h5A, 1'b0, "R7");
    run(3'b111, '1, '1, 1'b0, "R9");
    run(3'b000, '1, '1, 1'b0, "R9");

    // R1 again mid-run
    @(negedge clk);
    rst = 1'b1; mode = 3'b110; opa = '1; opb = '1;
    @(negedge clk);
    check("R1", {1'b1, {W{1'b1}}});
    rst = 1'b0;

    // exhaustive 4-bit operands, all modes, both carry-ins
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++)
            run(3'(m), W'(a), W'(b), 1'(c), req_of(3'(m)));

    // random full-width operands
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] m;
      m = (k % 5 == 4) ? 3'($urandom) : ((k % 4 == 0) ? 3'b100 : (k % 4 == 1) ? 3'b110 :
                                          (k % 4 == 2) ? 3'b001 : 3'b101);
      run(m, W'($urandom), W'($urandom), 1'($urandom), req_of(m));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule